// File: doc/BRIEF.md
# Dual General-Purpose Port with Pin Assignment

This block provides two general-purpose I/O ports, A and B, each `PORT_W` pins wide, controlled over a byte-wide register bus. Each port has three registers:

- a data register;
- a direction register, where 1 means output;
- an assignment register, where 1 means the pin is in general-purpose use.

Port A also has a second assignment register. That register is stored and read back but drives nothing.

A pin drives its output only when it is both an output and assigned. Data written to a port is masked the same way before it is stored. Reading a data register combines two sources:

- the stored bits on output pins;
- the synchronized external levels on input pins.

Port B's data register answers at two addresses.

Bus requests use a valid/ready handshake. `req_ready` is always high, so there is no back-pressure: every cycle with `req_valid` high is one accepted access. A read returns its data with `rsp_valid` on the cycle after acceptance, and the response has no ready of its own. A write produces no response.

Top module: `gpio_pinmux_pair`

## Requirements
- R1: After reset, the registers hold these values:
  - both direction registers read 0x00;
  - port A assignment 1 and port B assignment read 0xFF;
  - port A assignment 2 reads 0x00;
  - both data registers hold 0x00, so every output and output-enable is 0.
- R2: The byte offsets are:
  - port A: data 0x11, direction 0x13, assignment 1 0x15, assignment 2 0x17;
  - port B: data 0x19, data mirror 0x1B, direction 0x1D, assignment 0x1F.
- R3: A write to a data register stores write data AND direction AND assignment. The stored value appears on that port's `*_out` pins from the cycle after acceptance.
- R4: Each pin's output-enable equals its direction bit AND its assignment bit. It changes only after a write to that port's direction or assignment register.
- R5: A read of a data register returns two things merged:
  - the stored bit where the direction bit is 1;
  - the synchronized input pin where the direction bit is 0.
- R6: Reads and writes at offset 0x1B behave exactly like offset 0x19.
- R7: Direction and assignment registers, including port A assignment 2, read back exactly what was last written to them.
- R8: An unmapped offset reads 0x00, and a write to it changes no register and no output.
- R9: Input pins pass through a two-flop synchronizer. A level first sampled at clock edge k is returned by data reads accepted at edge k+2 or later. A read accepted at edge k+1 still returns the previous level.
- R10: `req_ready` is always 1. Every accepted read raises `rsp_valid` for exactly the next cycle. Writes never raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access request |
| req_ready | output | 1 | Access accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | PORT_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | PORT_W | Read data |
| pa_in | input | PORT_W | Port A external pin levels |
| pa_out | output | PORT_W | Port A output levels |
| pa_oe | output | PORT_W | Port A output enables |
| pb_in | input | PORT_W | Port B external pin levels |
| pb_out | output | PORT_W | Port B output levels |
| pb_oe | output | PORT_W | Port B output enables |

## Verification
The bench builds the block with its defaults: 8-bit ports, a 2-stage synchronizer and the reset values listed in R1. With these values, non-trivial direction and assignment patterns can be set on either port. Each data read then mixes stored output bits with live input bits, so both the AND masking on writes and the merge on reads can be checked bit by bit. Because the synchronizer is exactly two stages deep, the stale-versus-fresh boundary of R9 falls on fixed cycles that a short series of back-to-back reads reaches directly.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;

  localparam int unsigned BUS_AW = 8;

  localparam logic [BUS_AW-1:0] OFS_A_DATA = 8'h11;
  localparam logic [BUS_AW-1:0] OFS_A_DIR  = 8'h13;
  localparam logic [BUS_AW-1:0] OFS_A_ASN  = 8'h15;
  localparam logic [BUS_AW-1:0] OFS_A_AUX  = 8'h17;
  localparam logic [BUS_AW-1:0] OFS_B_DATA = 8'h19;
  localparam logic [BUS_AW-1:0] OFS_B_MIRR = 8'h1B;
  localparam logic [BUS_AW-1:0] OFS_B_DIR  = 8'h1D;
  localparam logic [BUS_AW-1:0] OFS_B_ASN  = 8'h1F;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_A_DATA,
    SEL_A_DIR,
    SEL_A_ASN,
    SEL_A_AUX,
    SEL_B_DATA,
    SEL_B_DIR,
    SEL_B_ASN
  } reg_sel_e;

  typedef struct packed {
    logic a_data;
    logic a_dir;
    logic a_asn;
    logic a_aux;
    logic b_data;
    logic b_dir;
    logic b_asn;
  } reg_we_t;

  function automatic reg_sel_e decode_offset(input logic [BUS_AW-1:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_A_DATA: s = SEL_A_DATA;
      OFS_A_DIR:  s = SEL_A_DIR;
      OFS_A_ASN:  s = SEL_A_ASN;
      OFS_A_AUX:  s = SEL_A_AUX;
      OFS_B_DATA,
      OFS_B_MIRR: s = SEL_B_DATA;
      OFS_B_DIR:  s = SEL_B_DIR;
      OFS_B_ASN:  s = SEL_B_ASN;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regdec.sv
module gpio_regdec
  import gpio_pinmux_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  output reg_sel_e          sel,
  output reg_we_t           we
);
  logic wr_go;

  assign sel   = decode_offset(req_addr);
  assign wr_go = req_valid && req_write;

  always_comb begin
    we        = '0;
    we.a_data = wr_go && (sel == SEL_A_DATA);
    we.a_dir  = wr_go && (sel == SEL_A_DIR);
    we.a_asn  = wr_go && (sel == SEL_A_ASN);
    we.a_aux  = wr_go && (sel == SEL_A_AUX);
    we.b_data = wr_go && (sel == SEL_B_DATA);
    we.b_dir  = wr_go && (sel == SEL_B_DIR);
    we.b_asn  = wr_go && (sel == SEL_B_ASN);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [W-1:0] DIR_RST    = '0,
  parameter logic [W-1:0] ASN_RST    = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_data,
  input  logic         we_dir,
  input  logic         we_asn,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] data_rd,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] asn_q
);
  logic [W-1:0] data_q;
  logic [W-1:0] pin_sync;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_RST;
      asn_q  <= ASN_RST;
      data_q <= '0;
    end else begin
      if (we_dir)  dir_q  <= wdata;
      if (we_asn)  asn_q  <= wdata;
      if (we_data) data_q <= wdata & dir_q & asn_q;
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q & asn_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign data_rd[i] = dir_q[i] ? data_q[i] : pin_sync[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_pinmux_pair.sv
module gpio_pinmux_pair
  import gpio_pinmux_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [PORT_W-1:0] A_ASN_RST = '1,
  parameter logic [PORT_W-1:0] A_AUX_RST = '0,
  parameter logic [PORT_W-1:0] B_ASN_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [PORT_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [PORT_W-1:0] rsp_rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe
);
  localparam logic [PORT_W-1:0] DIR_RST = '0;

  reg_sel_e          sel;
  reg_we_t           we;
  logic [PORT_W-1:0] pa_rd, pa_dir, pa_asn, pa_aux_q;
  logic [PORT_W-1:0] pb_rd, pb_dir, pb_asn;
  logic [PORT_W-1:0] rd_mux;
  logic              rd_go;

  assign req_ready = 1'b1;
  assign rd_go     = req_valid && !req_write;

  gpio_regdec u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .sel       (sel),
    .we        (we)
  );

  gpio_port #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES),
              .DIR_RST(DIR_RST), .ASN_RST(A_ASN_RST)) u_port_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_data (we.a_data),
    .we_dir  (we.a_dir),
    .we_asn  (we.a_asn),
    .wdata   (req_wdata),
    .pin_in  (pa_in),
    .pin_out (pa_out),
    .pin_oe  (pa_oe),
    .data_rd (pa_rd),
    .dir_q   (pa_dir),
    .asn_q   (pa_asn)
  );

  gpio_port #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES),
              .DIR_RST(DIR_RST), .ASN_RST(B_ASN_RST)) u_port_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_data (we.b_data),
    .we_dir  (we.b_dir),
    .we_asn  (we.b_asn),
    .wdata   (req_wdata),
    .pin_in  (pb_in),
    .pin_out (pb_out),
    .pin_oe  (pb_oe),
    .data_rd (pb_rd),
    .dir_q   (pb_dir),
    .asn_q   (pb_asn)
  );

  // Port A second assignment register: stored and read back only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pa_aux_q <= A_AUX_RST;
    else if (we.a_aux) pa_aux_q <= req_wdata;
  end

  always_comb begin
    case (sel)
      SEL_A_DATA: rd_mux = pa_rd;
      SEL_A_DIR:  rd_mux = pa_dir;
      SEL_A_ASN:  rd_mux = pa_asn;
      SEL_A_AUX:  rd_mux = pa_aux_q;
      SEL_B_DATA: rd_mux = pb_rd;
      SEL_B_DIR:  rd_mux = pb_dir;
      SEL_B_ASN:  rd_mux = pb_asn;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk
  import gpio_pinmux_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [BUS_AW-1:0] req_addr,
  input logic [PORT_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [PORT_W-1:0] pa_out,
  input logic [PORT_W-1:0] pa_oe,
  input logic [PORT_W-1:0] pb_out,
  input logic [PORT_W-1:0] pb_oe
);
  logic wr, mapped;
  assign wr = req_valid && req_write;
  assign mapped = (req_addr == OFS_A_DATA) || (req_addr == OFS_A_DIR) ||
                  (req_addr == OFS_A_ASN)  || (req_addr == OFS_A_AUX) ||
                  (req_addr == OFS_B_DATA) || (req_addr == OFS_B_MIRR) ||
                  (req_addr == OFS_B_DIR)  || (req_addr == OFS_B_ASN);

  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);

  // R10
  rsp_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R10
  read_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R3
  pa_out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pa_out) |-> $past(wr && req_addr == OFS_A_DATA));

  // R4
  pa_oe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pa_oe) |-> $past(wr && (req_addr == OFS_A_DIR || req_addr == OFS_A_ASN)));

  // R6
  mirror_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == OFS_B_MIRR) |=> (pb_out == ($past(req_wdata) & pb_oe)));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mapped) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe)));
endmodule

bind gpio_pinmux_pair gpio_pinmux_chk #(.PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .pa_out    (pa_out),
  .pa_oe     (pa_oe),
  .pb_out    (pb_out),
  .pb_oe     (pb_oe)
);

// File: tb/sim_gpio_pinmux_pair.sv
module sim_gpio_pinmux_pair;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready, rsp_valid;
  logic [7:0] req_addr = '0;
  logic [W-1:0] req_wdata = '0, rsp_rdata;
  logic [W-1:0] pa_in = 8'h5A, pb_in = 8'hC3;
  logic [W-1:0] pa_out, pa_oe, pb_out, pb_oe;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] got;

  always #5 clk = ~clk;

  gpio_pinmux_pair u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  // {write, addr, wdata, expected read}
  localparam int NV = 27;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h13, 8'h00, 8'h00},  // R1 R2 A dir reset
    {1'b0, 8'h15, 8'h00, 8'hFF},  // R1 A asn1 reset
    {1'b0, 8'h17, 8'h00, 8'h00},  // R1 A asn2 reset
    {1'b0, 8'h1F, 8'h00, 8'hFF},  // R1 B asn reset
    {1'b0, 8'h1D, 8'h00, 8'h00},  // R1 B dir reset
    {1'b0, 8'h11, 8'h00, 8'h5A},  // R5 all inputs
    {1'b0, 8'h19, 8'h00, 8'hC3},  // R5 all inputs
    {1'b1, 8'h13, 8'hF0, 8'h00},
    {1'b1, 8'h15, 8'h3C, 8'h00},
    {1'b1, 8'h11, 8'hFF, 8'h00},  // R3 stores 0x30
    {1'b0, 8'h11, 8'h00, 8'h3A},  // R5 mix
    {1'b0, 8'h13, 8'h00, 8'hF0},  // R7
    {1'b0, 8'h15, 8'h00, 8'h3C},  // R7
    {1'b1, 8'h17, 8'hA5, 8'h00},
    {1'b0, 8'h17, 8'h00, 8'hA5},  // R7 asn2
    {1'b1, 8'h1D, 8'h0F, 8'h00},
    {1'b1, 8'h1B, 8'h66, 8'h00},  // R6 mirror write stores 0x06
    {1'b0, 8'h19, 8'h00, 8'hC6},  // R6 R5
    {1'b0, 8'h1B, 8'h00, 8'hC6},  // R6 mirror read
    {1'b1, 8'h1F, 8'h01, 8'h00},
    {1'b1, 8'h19, 8'hFF, 8'h00},  // R3 stores 0x01
    {1'b0, 8'h1B, 8'h00, 8'hC1},  // R6
    {1'b1, 8'h12, 8'h77, 8'h00},  // R8 unmapped write
    {1'b0, 8'h12, 8'h00, 8'h00},  // R8 unmapped read
    {1'b0, 8'h00, 8'h00, 8'h00},  // R8
    {1'b0, 8'h1D, 8'h00, 8'h0F},  // R8 R7 unchanged
    {1'b0, 8'h13, 8'h00, 8'hF0}   // R8 R7 unchanged
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // call just after a negedge; returns just after the following negedge
  task automatic bus_wr(input logic [7:0] a, input logic [W-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R10 no rsp on write", {7'd0, rsp_valid}, 8'h00);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [W-1:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid after read", {7'd0, rsp_valid}, 8'h01);
    check("R10 req_ready", {7'd0, req_ready}, 8'h01);
    d = rsp_rdata;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 outputs after reset
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R10 idle rsp", {7'd0, rsp_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) bus_wr(VEC[i][23:16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][23:16], got);
        check($sformatf("R2 R5 R7 vector %0d addr %h", i, VEC[i][23:16]), got, VEC[i][7:0]);
      end
    end

    // R3 R4 output pins and enables
    check("R3 pa_out", pa_out, 8'h30);
    check("R4 pa_oe", pa_oe, 8'h30);
    check("R3 pb_out", pb_out, 8'h01);
    check("R4 pb_oe", pb_oe, 8'h01);

    // R9 synchronizer latency: low nibble of A is input
    pa_in = 8'h55;
    bus_rd(8'h11, got); check("R9 read at edge k", got, 8'h3A);
    bus_rd(8'h11, got); check("R9 read at edge k+1", got, 8'h3A);
    bus_rd(8'h11, got); check("R9 read at edge k+2", got, 8'h35);

    // R4 clearing assignment drops enable; R3 stored value stays masked
    bus_wr(8'h15, 8'h00);
    check("R4 pa_oe after asn clear", pa_oe, 8'h00);
    bus_wr(8'h11, 8'hFF);
    check("R3 pa_out with no assigned pins", pa_out, 8'h00);

    // R1 reset restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_rd(8'h15, got); check("R1 asn1 after reset", got, 8'hFF);
    bus_rd(8'h17, got); check("R1 asn2 after reset", got, 8'h00);
    check("R1 pb_out after reset", pb_out, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule